// File: doc/BRIEF.md
# Windowed Watchdog Timer with Key-Sequence Service

This block is a watchdog counter that asks for a system reset when software stops servicing it. It counts cycles of a free-running watchdog clock enable. A control register sets the timeout rate, an optional window mode, a debug-halt option and a write mask. Software services the watchdog by writing a two-byte key to a separate arm register: first 0x55, then 0xAA. When the 0xAA lands after a 0x55, the timeout period starts again.

In window mode, servicing is legal only in the final quarter of the period. A premature arm write is treated as a fault. Under debug, the counter can either freeze or keep running. When the chip is in special mode and debug is active with the halt option clear, the block ignores its rate and window settings and runs at the longest period without a window. Outside special mode, the rate and window fields can be set once after reset. A masked control write changes only the halt flag.

Top module: `wdt_window`

## Requirements
- R1: After reset, stat_rate is 0, stat_window is 0, stat_halt is 0, stat_enabled is 0 and rst_req is 0. While the rate is 0, arm-register writes of any value raise no reset request and no timeout occurs.
- R2: A control write (wr_en=1, wr_arm=0) uses these wr_data fields: rate in bits 2:0, window enable in bit 4, debug halt in bit 5 and write mask in bit 7. When the write is accepted with a nonzero rate, the watchdog is enabled and a fresh period starts from a count of zero.
- R3: The rate selects a period of 2^(E-RATE_SHIFT) counted ticks. E is 14, 16, 18, 20, 22, 23 and 24 for rates 1 to 7. If the period elapses without service, rst_req is high for exactly one clock cycle. That cycle is the one after the clock edge on which the final tick is counted.
- R4: An arm write (wr_en=1, wr_arm=1) of 0x55 followed by an arm write of 0xAA restarts the period. The next timeout then falls a full period after the 0xAA.
- R5: While the watchdog is enabled, an arm write of any value other than 0x55 or 0xAA, or an 0xAA with no 0x55 before it, raises rst_req in the cycle after the write.
- R6: With window mode in effect, an arm write made while the count is below three quarters of the period raises rst_req in the next cycle. In the last quarter, 0x55 may be written any number of times before the 0xAA is accepted. A write made just after that restart is early again.
- R7: A control write with bit 7 set updates only the halt flag. It leaves the rate and window fields unchanged and does not use up the single allowed write.
- R8: Outside special mode, only the first unmasked control write after reset changes the rate and window fields, and later ones leave them unchanged. In special mode these fields can be rewritten at any time.
- R9: With the halt flag set, the count freezes while dbg_active is high. With the halt flag clear, the count keeps running under debug.
- R10: When the watchdog is enabled, dbg_active is high, the halt flag is clear and special_mode is high, the period is 2^(24-RATE_SHIFT) and window mode is not applied.
- R11: The count advances only in cycles where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Watchdog clock enable, one count per high cycle |
| dbg_active | input | 1 | Debug session is active |
| special_mode | input | 1 | Chip runs in special mode |
| wr_en | input | 1 | Register write strobe |
| wr_arm | input | 1 | 1 selects the arm register, 0 selects the control register |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | One-cycle system reset request |
| stat_rate | output | 3 | Current rate field |
| stat_window | output | 1 | Current window-enable field |
| stat_halt | output | 1 | Current debug-halt flag |
| stat_enabled | output | 1 | Watchdog enabled (rate nonzero) |

## Verification
The assertions take for granted that the inputs hold steady from one clock edge to the next, that writes arrive at most once per cycle as single-cycle strobes, and that the count never grows beyond the longest period. The bench drives every input on the falling edge and issues writes only through tasks that hold the strobe for one cycle. It shortens all periods through RATE_SHIFT, so even the longest period stays within the counter width. A behavioural model in the bench tracks the reset request and the status outputs on every clock. Directed checks time each timeout and each fault to the exact cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int MAX_EXP  = 24;
    localparam int BIT_WIN  = 4;
    localparam int BIT_HALT = 5;
    localparam int BIT_MASK = 7;
    localparam logic [7:0] KEY_PRIME = 8'h55;
    localparam logic [7:0] KEY_FIRE  = 8'hAA;

    typedef struct packed {
        logic       win;
        logic       halt;
        logic [2:0] rate;
    } cfg_t;

    typedef enum logic [1:0] {
        ARM_NONE,
        ARM_PRIME,
        ARM_RESTART,
        ARM_FAULT
    } arm_dec_t;

    // exponent of the period for a rate code (rate 0 unused)
    function automatic logic [5:0] rate_exp(input logic [2:0] rate);
        logic [5:0] r;
        r = {3'b000, rate};
        if (rate <= 3'd5) return 6'd12 + (r << 1);
        return 6'd17 + r;
    endfunction
endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_ctrl,
    input  logic [7:0] data,
    input  logic       special_mode,
    output cfg_t       cfg,
    output logic       start
);
    logic once_q;
    logic accept;

    assign accept = wr_ctrl && !data[BIT_MASK] && (special_mode || !once_q);
    assign start  = accept && (data[2:0] != 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            once_q <= 1'b0;
        end else if (wr_ctrl) begin
            cfg.halt <= data[BIT_HALT];
            if (accept) begin
                cfg.rate <= data[2:0];
                cfg.win  <= data[BIT_WIN];
                once_q   <= 1'b1;
            end
        end
    end

    assert_mask_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && data[BIT_MASK]) |=> ($stable(cfg.rate) && $stable(cfg.win)));

    assert_write_once_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && once_q && !special_mode) |=> ($stable(cfg.rate) && $stable(cfg.win)));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int SHIFT = 0
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       freeze,
    input  logic       ovr,
    input  logic [2:0] rate,
    input  logic       clear,
    output logic       win_open,
    output logic       expire
);
    localparam int CW = MAX_EXP - SHIFT + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] period;
    logic [CW-1:0] last;
    logic [CW-1:0] open_at;
    logic [5:0]    e;
    logic          step;

    always_comb begin
        e       = (ovr ? 6'(MAX_EXP) : rate_exp(rate)) - 6'(SHIFT);
        period  = CW'(1) << e;
        last    = period - CW'(1);
        open_at = period - (period >> 2);
    end

    assign step     = en && tick && !freeze;
    assign expire   = step && (cnt_q >= last);
    assign win_open = cnt_q >= open_at;

    always_ff @(posedge clk) begin
        if (rst || !en || clear || expire) cnt_q <= '0;
        else if (step)                     cnt_q <= cnt_q + CW'(1);
    end

    assert_idle_count_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0));

    assert_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (en && freeze && !clear) |=> $stable(cnt_q));

    assert_tick_only_R11: assert property (@(posedge clk) disable iff (rst)
        (en && !tick && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_arm.sv
module wdt_arm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_arm,
    input  logic [7:0] data,
    input  logic       en,
    input  logic       win_eff,
    input  logic       win_open,
    input  logic       drop,
    output logic       restart,
    output logic       fault
);
    logic     armed_q;
    arm_dec_t dec;

    always_comb begin
        dec = ARM_NONE;
        if (wr_arm && en) begin
            if (win_eff && !win_open)                 dec = ARM_FAULT;
            else if (data == KEY_PRIME)               dec = ARM_PRIME;
            else if (data == KEY_FIRE && armed_q)     dec = ARM_RESTART;
            else                                      dec = ARM_FAULT;
        end
    end

    assign restart = (dec == ARM_RESTART);
    assign fault   = (dec == ARM_FAULT);

    always_ff @(posedge clk) begin
        if (rst || !en)                     armed_q <= 1'b0;
        else if (dec == ARM_PRIME)          armed_q <= 1'b1;
        else if (dec != ARM_NONE || drop)   armed_q <= 1'b0;
    end
endmodule

// File: rtl/wdt_window.sv
module wdt_window
    import wdt_pkg::*;
#(
    parameter int RATE_SHIFT = 0
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       dbg_active,
    input  logic       special_mode,
    input  logic       wr_en,
    input  logic       wr_arm,
    input  logic [7:0] wr_data,
    output logic       rst_req,
    output logic [2:0] stat_rate,
    output logic       stat_window,
    output logic       stat_halt,
    output logic       stat_enabled
);
    cfg_t cfg;
    logic start, en, ovr, freeze, win_eff;
    logic win_open, expire, restart, fault;
    logic unused_bits;

    assign unused_bits = ^{wr_data[6], wr_data[3]};

    wdt_cfg u_cfg (
        .clk          (clk),
        .rst          (rst),
        .wr_ctrl      (wr_en && !wr_arm),
        .data         (wr_data),
        .special_mode (special_mode),
        .cfg          (cfg),
        .start        (start)
    );

    assign en      = (cfg.rate != 3'd0);
    assign ovr     = en && dbg_active && !cfg.halt && special_mode;
    assign freeze  = cfg.halt && dbg_active;
    assign win_eff = cfg.win && !ovr;

    wdt_counter #(.SHIFT(RATE_SHIFT)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (tick),
        .freeze   (freeze),
        .ovr      (ovr),
        .rate     (cfg.rate),
        .clear    (start || restart || fault),
        .win_open (win_open),
        .expire   (expire)
    );

    wdt_arm u_arm (
        .clk      (clk),
        .rst      (rst),
        .wr_arm   (wr_en && wr_arm),
        .data     (wr_data),
        .en       (en),
        .win_eff  (win_eff),
        .win_open (win_open),
        .drop     (expire || start),
        .restart  (restart),
        .fault    (fault)
    );

    always_ff @(posedge clk) begin
        if (rst) rst_req <= 1'b0;
        else     rst_req <= fault || expire;
    end

    assign stat_rate    = cfg.rate;
    assign stat_window  = cfg.win;
    assign stat_halt    = cfg.halt;
    assign stat_enabled = en;

    assert_bad_key_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_arm && en && wr_data != KEY_PRIME && wr_data != KEY_FIRE) |=> rst_req);

    assert_early_service_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_arm && en && cfg.win && !ovr && !win_open) |=> rst_req);

    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!en && !start) |=> !rst_req);
endmodule

// File: tb/wdt_window_bench.sv
module wdt_window_bench;
    localparam int SHIFT = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1, dbg_active = 1'b0, special_mode = 1'b0;
    logic wr_en = 1'b0, wr_arm = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic rst_req, stat_window, stat_halt, stat_enabled;
    logic [2:0] stat_rate;
    int tick_mode = 0;

    always #5 clk = ~clk;

    wdt_window #(.RATE_SHIFT(SHIFT)) u_wdt_window (
        .clk(clk), .rst(rst), .tick(tick), .dbg_active(dbg_active),
        .special_mode(special_mode), .wr_en(wr_en), .wr_arm(wr_arm),
        .wr_data(wr_data), .rst_req(rst_req), .stat_rate(stat_rate),
        .stat_window(stat_window), .stat_halt(stat_halt), .stat_enabled(stat_enabled)
    );

    int checks = 0, fails = 0, cycles = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int m_rate, m_win, m_halt, m_once, m_cnt, m_armed, m_req;
    bit live = 0;

    function automatic int period_of(input int rate, input bit ov);
        int e;
        if (ov) e = 24;
        else case (rate)
            1: e = 14; 2: e = 16; 3: e = 18; 4: e = 20;
            5: e = 22; 6: e = 23; default: e = 24;
        endcase
        return 1 << (e - SHIFT);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_rate = 0; m_win = 0; m_halt = 0; m_once = 0;
            m_cnt = 0; m_armed = 0; m_req = 0; live = 1;
        end else begin
            bit en, ov, frz, weff, clr, flt, exp_now;
            int per, nrate, nwin, nhalt;
            en = (m_rate != 0);
            ov = en && dbg_active && !m_halt && special_mode;
            frz = m_halt && dbg_active;
            weff = m_win && !ov;
            per = period_of(m_rate, ov);
            clr = 0; flt = 0;
            nrate = m_rate; nwin = m_win; nhalt = m_halt;
            if (wr_en && !wr_arm) begin
                nhalt = wr_data[5];
                if (!wr_data[7] && (special_mode || !m_once)) begin
                    nrate = wr_data[2:0]; nwin = wr_data[4]; m_once = 1;
                    if (nrate != 0) clr = 1;
                end
            end
            if (wr_en && wr_arm && en) begin
                if (weff && m_cnt * 4 < per * 3) flt = 1;
                else if (wr_data == 8'h55) m_armed = 1;
                else if (wr_data == 8'hAA && m_armed) clr = 1;
                else flt = 1;
            end
            exp_now = en && tick && !frz && (m_cnt >= per - 1);
            m_req = flt || exp_now;
            if (!en || clr || flt || exp_now) m_cnt = 0;
            else if (tick && !frz) m_cnt = m_cnt + 1;
            if (!en || flt || exp_now || clr) begin
                if (!(wr_en && wr_arm && en && wr_data == 8'h55 && !flt)) m_armed = 0;
            end
            m_rate = nrate; m_win = nwin; m_halt = nhalt;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (tick_mode == 1) tick = ~tick;
        if (live && !rst) begin
            check(rst_req == m_req[0], "model rst_req R3 R5", rst_req, m_req);
            check(stat_rate == m_rate[2:0], "model rate R2 R8", stat_rate, m_rate);
            check(stat_window == m_win[0], "model window R2", stat_window, m_win);
            check(stat_halt == m_halt[0], "model halt R7", stat_halt, m_halt);
        end
    end

    task automatic do_reset();
        dbg_active = 0; special_mode = 0; tick_mode = 0; tick = 1;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic wr(input bit arm, input logic [7:0] d);
        wr_en = 1; wr_arm = arm; wr_data = d;
        @(negedge clk);
        wr_en = 0; wr_arm = 0; wr_data = 8'h00;
    endtask

    task automatic wait_req(input int max, output int k);
        k = -1;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (rst_req) begin k = i; break; end
        end
    endtask

    int k;

    initial begin
        do_reset();
        check(rst_req == 0 && stat_rate == 0 && stat_window == 0 && stat_halt == 0 && stat_enabled == 0,
              "R1 reset state", {stat_rate, stat_window, stat_halt, rst_req}, 0);
        wr(1, 8'h13);
        check(rst_req == 0, "R1 arm write while disabled", rst_req, 0);
        wait_req(100, k);
        check(k == -1, "R1 no timeout while disabled", k, -1);

        wr(0, 8'h01);
        check(stat_enabled == 1, "R2 enable", stat_enabled, 1);
        wait_req(200, k);
        check(k == 64, "R3 rate1 timeout", k, 64);
        @(negedge clk);
        check(rst_req == 0, "R3 pulse width", rst_req, 0);

        do_reset(); wr(0, 8'h02); wait_req(400, k);
        check(k == 256, "R3 rate2 timeout", k, 256);
        do_reset(); wr(0, 8'h03); wait_req(1200, k);
        check(k == 1024, "R3 rate3 timeout", k, 1024);

        do_reset(); wr(0, 8'h01);
        repeat (30) @(negedge clk);
        wr(1, 8'h55); wr(1, 8'hAA);
        check(rst_req == 0, "R4 service accepted", rst_req, 0);
        wait_req(200, k);
        check(k == 64, "R4 period after restart", k, 64);

        do_reset(); wr(0, 8'h01); repeat (5) @(negedge clk);
        wr(1, 8'h3C);
        check(rst_req == 1, "R5 bad key", rst_req, 1);
        do_reset(); wr(0, 8'h01); repeat (5) @(negedge clk);
        wr(1, 8'hAA);
        check(rst_req == 1, "R5 lone 0xAA", rst_req, 1);

        do_reset(); wr(0, 8'h12); repeat (50) @(negedge clk);
        wr(1, 8'h55);
        check(rst_req == 1, "R6 early write", rst_req, 1);
        do_reset(); wr(0, 8'h12); repeat (200) @(negedge clk);
        wr(1, 8'h55); wr(1, 8'h55); wr(1, 8'h55); wr(1, 8'hAA);
        check(rst_req == 0, "R6 service in window", rst_req, 0);
        wr(1, 8'h55);
        check(rst_req == 1, "R6 write after restart is early", rst_req, 1);

        do_reset(); wr(0, 8'hA3);
        check(stat_halt == 1 && stat_rate == 0, "R7 masked write", {stat_halt, stat_rate}, 8);
        wr(0, 8'h01);
        check(stat_rate == 1, "R7 once not consumed", stat_rate, 1);
        wr(0, 8'h02);
        check(stat_rate == 1, "R8 second write ignored", stat_rate, 1);
        special_mode = 1;
        wr(0, 8'h02);
        check(stat_rate == 2, "R8 special mode rewrite", stat_rate, 2);

        do_reset(); wr(0, 8'h21); dbg_active = 1;
        wait_req(200, k);
        check(k == -1, "R9 frozen under debug", k, -1);
        dbg_active = 0; wait_req(200, k);
        check(k == 64, "R9 resumes", k, 64);
        do_reset(); wr(0, 8'h01); dbg_active = 1;
        wait_req(200, k);
        check(k == 64, "R9 runs with halt clear", k, 64);

        do_reset(); special_mode = 1; wr(0, 8'h11); dbg_active = 1;
        repeat (5) @(negedge clk);
        wr(1, 8'h55); wr(1, 8'hAA);
        check(rst_req == 0, "R10 window ignored", rst_req, 0);
        wait_req(150, k);
        check(k == -1, "R10 long period", k, -1);

        do_reset(); tick_mode = 1; wr(0, 8'h01); wait_req(300, k);
        check(k >= 126 && k <= 130, "R11 half-rate ticks", k, 128);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        fails++; checks++;
        $display("FAIL watchdog expired R1 actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule